// File: doc/BRIEF.md
# Serial Register-Access Slave Port

This block is the slave side of a four-wire serial link. An external microcontroller uses it to read and write a bank of 8-bit configuration registers. The link has four signals: an active-low select, a serial clock, a data-in line and a data-out line that can be tri-stated. The data-out line is brought out as a value and an output enable, so the pad driver or the bench can build the tri-state buffer. The serial signals arrive asynchronously to the system clock. The block synchronizes them and then works entirely in the system clock domain.

Every frame opens with a 7-bit device identifier, sent MSB first, followed by a direction bit.

- **Write frame:** a pointer byte follows, then zero or more data bytes. Each complete data byte is written to the register at the pointer, and the pointer then advances.
- **Read frame:** no pointer is carried. Data is shifted out from the register at the pointer that the last write frame left behind. That write may have been partial, ending right after its pointer byte. The pointer advances after each byte.

The register bank sits outside the block. It sees an address, write data, a one-cycle write strobe, and a read-data return that the port samples at the start of every outgoing byte.

Top module: `spi_cfg_port`

## Requirements
- R1: Serial input is sampled on rising serial-clock edges, MSB first. The first seven bits of a frame must equal the DEV_ADDR parameter (default 7'b0010000). The eighth bit selects the direction: 0 is write, 1 is read.
- R2: In a write frame, the byte after the direction bit loads the pointer. Each following complete byte produces exactly one single-cycle `reg_we_o` pulse, with `reg_addr_o` set to the pointer and `reg_wdata_o` set to the byte.
- R3: The pointer advances by one after every complete data byte, whether written or read, and wraps from 8'hFF to 8'h00.
- R4: A write frame that ends right after its pointer byte changes only the pointer and produces no write pulse.
- R5: In a read frame, `miso_oe_o` rises on the first falling serial-clock edge after the direction bit, and `miso_o` carries the MSB of the register at the pointer. Each later falling edge presents the next bit. Successive bytes come from successive registers.
- R6: `miso_oe_o` stays low during write frames and while select is high, and is never high while a write pulse is issued.
- R7: If the device identifier does not match, the rest of the frame is ignored: no write pulse, the pointer is unchanged, and `miso_oe_o` stays low.
- R8: Select going high at any point aborts the frame and clears the bit count. A partially received byte is discarded without a write, and the next frame starts with a fresh device identifier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Serial select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Drive enable for miso_o (low means high impedance) |
| reg_addr_o | output | 8 | Register bank address (pointer, or write address during a write pulse) |
| reg_wdata_o | output | 8 | Register bank write data |
| reg_we_o | output | 1 | Register bank write strobe, one cycle per byte |
| reg_rdata_i | input | 8 | Register bank read data at reg_addr_o |

## Verification
The assertions check the following on every cycle:
- The output enable drops once the synchronized select is high.
- A write pulse never coincides with a driven data-out line.
- A write pulse lasts one cycle and only follows a cycle in which the port was selected.
- The data-out value changes only after a falling serial-clock edge.

The bench scenarios are needed for everything that depends on a whole frame:
- identifier matching;
- pointer loading, including pointer-only frames;
- auto-increment across the 8'hFF wrap;
- read-back of values written earlier;
- the effects of aborted and mismatched frames on later frames.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
    parameter int DW = 8;
    localparam int CW = $clog2(DW);

    typedef enum logic [2:0] {
        ST_DEV  = 3'd0,
        ST_PTR  = 3'd1,
        ST_WDAT = 3'd2,
        ST_RDAT = 3'd3,
        ST_SKIP = 3'd4
    } eng_st_e;

    typedef struct packed {
        eng_st_e       st;
        logic [CW-1:0] cnt;
        logic [DW-1:0] sh;
        logic [DW-1:0] ptr;
        logic [DW-1:0] tx;
        logic          oe;
        logic          sdo;
        logic          we;
        logic [DW-1:0] wa;
        logic [DW-1:0] wd;
    } eng_s;
endpackage

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
    parameter int           N       = 3,
    parameter int           STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        logic [STAGES-1:0] chain_d;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_i[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL[g]}};
            else        chain_q <= chain_d;
        end

        assign sync_o[g] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/spi_cfg_edge.sv
module spi_cfg_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o,
    output logic fall_o
);
    logic prev_q;
    logic prev_d;

    always_comb begin
        prev_d = lvl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign rise_o = lvl_i & ~prev_q;
    assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/spi_cfg_engine.sv
module spi_cfg_engine
    import spi_cfg_pkg::*;
#(
    parameter logic [DW-2:0] DEV_ADDR = 7'b0010000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_s,
    input  logic          mosi_s,
    input  logic          rise_ev,
    input  logic          fall_ev,
    input  logic [DW-1:0] rdata_i,
    output logic          sdo_o,
    output logic          oe_o,
    output logic [DW-1:0] addr_o,
    output logic [DW-1:0] wdata_o,
    output logic          we_o
);
    localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

    eng_s q, d;
    logic [DW-1:0] byte_full;
    logic          last;

    always_comb begin
        d         = q;
        d.we      = 1'b0;
        byte_full = {q.sh[DW-2:0], mosi_s};
        last      = (q.cnt == LAST_BIT);
        if (cs_s) begin
            d.st  = ST_DEV;
            d.cnt = '0;
            d.oe  = 1'b0;
        end else begin
            if (rise_ev) begin
                d.sh  = byte_full;
                d.cnt = last ? '0 : q.cnt + 1'b1;
                if (last) begin
                    unique case (q.st)
                        ST_DEV: begin
                            if (byte_full[DW-1:1] == DEV_ADDR)
                                d.st = byte_full[0] ? ST_RDAT : ST_PTR;
                            else
                                d.st = ST_SKIP;
                        end
                        ST_PTR: begin
                            d.ptr = byte_full;
                            d.st  = ST_WDAT;
                        end
                        ST_WDAT: begin
                            d.we  = 1'b1;
                            d.wa  = q.ptr;
                            d.wd  = byte_full;
                            d.ptr = q.ptr + 1'b1;
                        end
                        ST_RDAT: begin
                            d.ptr = q.ptr + 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
            if (fall_ev && q.st == ST_RDAT) begin
                d.oe = 1'b1;
                if (q.cnt == '0) begin
                    d.sdo = rdata_i[DW-1];
                    d.tx  = {rdata_i[DW-2:0], 1'b0};
                end else begin
                    d.sdo = q.tx[DW-1];
                    d.tx  = {q.tx[DW-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sdo_o   = q.sdo;
    assign oe_o    = q.oe;
    assign we_o    = q.we;
    assign wdata_o = q.wd;
    assign addr_o  = q.we ? q.wa : q.ptr;
endmodule

// File: rtl/spi_cfg_port.sv
module spi_cfg_port
    import spi_cfg_pkg::*;
#(
    parameter logic [DW-2:0] DEV_ADDR    = 7'b0010000,
    parameter int            SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n_i,
    input  logic          sclk_i,
    input  logic          mosi_i,
    output logic          miso_o,
    output logic          miso_oe_o,
    output logic [DW-1:0] reg_addr_o,
    output logic [DW-1:0] reg_wdata_o,
    output logic          reg_we_o,
    input  logic [DW-1:0] reg_rdata_i
);
    logic [2:0] sync_v;
    logic       cs_s, sclk_s, mosi_s;
    logic       rise_ev, fall_ev;

    spi_cfg_sync #(
        .N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)
    ) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_i({cs_n_i, sclk_i, mosi_i}),
        .sync_o(sync_v)
    );

    assign {cs_s, sclk_s, mosi_s} = sync_v;

    spi_cfg_edge u_edge (
        .clk(clk), .rst_n(rst_n), .lvl_i(sclk_s),
        .rise_o(rise_ev), .fall_o(fall_ev)
    );

    spi_cfg_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .cs_s(cs_s), .mosi_s(mosi_s),
        .rise_ev(rise_ev), .fall_ev(fall_ev),
        .rdata_i(reg_rdata_i),
        .sdo_o(miso_o), .oe_o(miso_oe_o),
        .addr_o(reg_addr_o), .wdata_o(reg_wdata_o), .we_o(reg_we_o)
    );
endmodule

// File: rtl/spi_cfg_port_chk.sv
module spi_cfg_port_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_s,
    input logic fall_ev,
    input logic miso_o,
    input logic miso_oe_o,
    input logic reg_we_o
);
    assert_oe_off_deselected_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !miso_oe_o);

    assert_no_drive_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |-> !miso_oe_o);

    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |=> !reg_we_o);

    assert_write_needs_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |-> !$past(cs_s));

    assert_sdo_moves_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (miso_oe_o && !$past(fall_ev)) |-> $stable(miso_o));
endmodule

bind spi_cfg_port spi_cfg_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .fall_ev(fall_ev),
    .miso_o(miso_o), .miso_oe_o(miso_oe_o), .reg_we_o(reg_we_o)
);

// File: tb/tb_spi_cfg_port.sv
module tb_spi_cfg_port;
    localparam int H = 8;
    localparam logic [6:0] ID = 7'b0010000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
    logic miso, miso_oe, we;
    logic [7:0] addr, wdata, rdata;

    logic [7:0] bank [256];
    logic [7:0] exp_mem [256];
    logic [15:0] wq [$];
    int n_chk = 0, n_bad = 0, hiz_err = 0, wr_seen = 0;
    bit expect_hiz = 1'b0;

    always #10 clk = ~clk;

    spi_cfg_port dut (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .mosi_i(mosi),
        .miso_o(miso), .miso_oe_o(miso_oe), .reg_addr_o(addr),
        .reg_wdata_o(wdata), .reg_we_o(we), .reg_rdata_i(rdata)
    );

    assign rdata = bank[addr];
    always @(posedge clk) if (we) bank[addr] <= wdata;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (expect_hiz && miso_oe) hiz_err++;
        if (we) begin
            wr_seen++;
            if (wq.size() == 0) check(1'b0, "R7 unexpected write", {addr, wdata}, 0);
            else begin
                logic [15:0] e;
                e = wq.pop_front();
                check({addr, wdata} == e, "R2 write addr/data", {addr, wdata}, e);
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        mosi = b;
        wait_clk(H);
        sclk = 1'b1;
        wait_clk(H);
        sclk = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
    endtask

    task automatic begin_frame();
        cs_n = 1'b0;
        wait_clk(H);
    endtask

    task automatic end_frame();
        wait_clk(H);
        cs_n = 1'b1;
        wait_clk(3 * H);
    endtask

    task automatic wr_frame(input logic [7:0] ptr, input logic [7:0] dat[$]);
        logic [7:0] p;
        p = ptr;
        expect_hiz = 1'b1;
        hiz_err = 0;
        begin_frame();
        send_byte({ID, 1'b0});
        send_byte(ptr);
        foreach (dat[i]) begin
            wq.push_back({p, dat[i]});
            exp_mem[p] = dat[i];
            send_byte(dat[i]);
            p = p + 8'd1;
        end
        end_frame();
        expect_hiz = 1'b0;
        check(hiz_err == 0, "R6 hi-z during write frame", hiz_err, 0);
    endtask

    task automatic rd_frame(input logic [7:0] ptr, input int n, input string req);
        logic [7:0] p, got;
        p = ptr;
        begin_frame();
        send_byte({ID, 1'b1});
        for (int k = 0; k < n; k++) begin
            got = '0;
            for (int i = 7; i >= 0; i--) begin
                wait_clk(H);
                check(miso_oe === 1'b1, {req, " R5 output enabled"}, miso_oe, 1);
                got[i] = miso;
                sclk = 1'b1;
                wait_clk(H);
                sclk = 1'b0;
            end
            check(got == exp_mem[p], req, got, exp_mem[p]);
            p = p + 8'd1;
        end
        end_frame();
        check(miso_oe == 1'b0, "R6 hi-z after deselect", miso_oe, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            bank[i] = 8'(i) ^ 8'hA5;
            exp_mem[i] = 8'(i) ^ 8'hA5;
        end
        wait_clk(4);
        check(miso_oe == 1'b0 && we == 1'b0, "R6 reset state", {miso_oe, we}, 0);
        rst_n = 1'b1;
        wait_clk(4);

        // R1 R2: single write
        wr_frame(8'h10, '{8'h3C});
        // R3: burst across the wrap
        wr_frame(8'hFE, '{8'h11, 8'h22, 8'h33});
        // R4: pointer-only frame, then R5 read of two consecutive registers
        wr_frame(8'h10, '{});
        rd_frame(8'h10, 2, "R4 R5 read after pointer set");
        // R3: pointer now 0x12 after the read frame
        rd_frame(8'h12, 1, "R3 pointer advanced by read");

        // R7: mismatched write identifier
        expect_hiz = 1'b1; hiz_err = 0;
        begin_frame();
        send_byte({7'b0010001, 1'b0});
        send_byte(8'h40);
        send_byte(8'h99);
        end_frame();
        // R7: mismatched read identifier
        begin_frame();
        send_byte({7'b1010000, 1'b1});
        send_byte(8'h00);
        end_frame();
        expect_hiz = 1'b0;
        check(hiz_err == 0, "R7 hi-z on mismatch", hiz_err, 0);
        rd_frame(8'h13, 1, "R7 pointer unchanged by mismatch");

        // R8: abort inside a data byte
        begin_frame();
        send_byte({ID, 1'b0});
        send_byte(8'h20);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        end_frame();
        rd_frame(8'h20, 1, "R8 partial byte discarded");
        // R8: abort inside the identifier, then a clean frame
        begin_frame();
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        end_frame();
        wr_frame(8'h30, '{8'h5A});
        rd_frame(8'hFF, 0, "R8 dummy");
        wr_frame(8'h30, '{});
        rd_frame(8'h30, 1, "R8 fresh frame after abort");

        // R3 R5: read across the wrap
        wr_frame(8'hFF, '{});
        rd_frame(8'hFF, 2, "R3 read wrap");

        wait_clk(10);
        check(wq.size() == 0, "R2 all writes seen", wq.size(), 0);
        check(wr_seen == 5, "R4 R7 R8 write count", wr_seen, 5);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule